// File: doc/BRIEF.md
# Narrow-Access Register Window Adapter

This block connects a 128-byte, byte-addressable, little-endian I/O window to three register targets that accept only whole 32-bit words: a bank of sixteen SCSI core registers, a bank of eight DMA registers and a single bus-control word. The bus side presents an address, a byte count, a write flag and write data. The adapter selects the target from the word address. It forwards each access as exactly one full-word read or write on that target's word-indexed port.

Writes of one to three bytes, and writes that do not start on a word boundary, are widened into a full word. The addressed byte lanes take the new data. Every other lane is filled from a shadow copy of the last value the adapter wrote to that word. The target is therefore never read during a write, and clear-on-read status bits keep their state. Reads fetch the aligned word and return only the requested bytes, right-justified.

The request handshake is always ready. Target strobes fire in the cycle the request is accepted, and a response appears one cycle later.

Top module: `sub_word_adapter`

## Requirements
- R1: Byte offsets 0x00 to 0x3F select the core target, and `core_idx` equals offset bits [5:2].
- R2: Byte offsets 0x40 to 0x5F select the DMA target, and `dma_idx` equals (offset − 0x40) >> 2.
- R3: Byte offsets 0x70 to 0x73 select the bus-control word.
- R4: Offsets 0x60 to 0x6F and 0x74 to 0x7F form a hole. A request there raises no target strobe, leaves every shadow unchanged and gets response data 0.
- R5: `req_size` holds the byte count minus one (0 means 1 byte, 3 means 4 bytes). Byte k of `req_wdata` (bits 8k+7:8k) belongs to byte lane (offset mod 4)+k. An aligned 4-byte write passes `req_wdata` to the target unchanged.
- R6: A narrow or unaligned write issues one full-word write. In that word, the lanes outside the addressed range equal the shadow of the last word written to the same target word.
- R7: Any byte whose lane would be 4 or higher is dropped, so the access stops at the end of the word.
- R8: A read returns the target word shifted right by 8 × (offset mod 4), with every bit from 8 × (req_size+1) upward set to zero.
- R9: Each accepted request raises at most one target strobe. A write never raises a read strobe, so merging does not read the target.
- R10: `req_ready` is always 1. `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. Target strobes occur in the acceptance cycle, and the response data of a write is 0.
- R11: After reset, `rsp_valid` and `rsp_rdata` are 0 and every shadow word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset in the window |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read bytes, right-justified |
| core_wr | output | 1 | Core word write strobe |
| core_rd | output | 1 | Core word read strobe |
| core_idx | output | 4 | Core word index |
| core_wdata | output | 32 | Core full-word write data |
| core_rdata | input | 32 | Core word read data |
| dma_wr | output | 1 | DMA word write strobe |
| dma_rd | output | 1 | DMA word read strobe |
| dma_idx | output | 3 | DMA word index |
| dma_wdata | output | 32 | DMA full-word write data |
| dma_rdata | input | 32 | DMA word read data |
| ctl_wr | output | 1 | Control word write strobe |
| ctl_rd | output | 1 | Control word read strobe |
| ctl_wdata | output | 32 | Control full-word write data |
| ctl_rdata | input | 32 | Control word read data |

## Verification
The hardest case is a narrow write where the target's live word differs from the value last written. Only there does a merge sourced from the target diverge from a merge sourced from the shadow.

The bench models each target as a word that drifts after every write: the live word becomes the written word XOR a fixed pattern. The live word and the shadow therefore always differ, and every later partial write exposes which one fed the unaddressed lanes.

Offsets near the word end, combined with large sizes, drive the truncation case. Accesses to the hole are mixed in among these writes to show that no shadow moves.

// File: rtl/sub_word_pkg.sv
package sub_word_pkg;
    typedef enum logic [1:0] {
        TGT_CORE = 2'd0,
        TGT_DMA  = 2'd1,
        TGT_CTL  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;
endpackage

// File: rtl/swa_decode.sv
module swa_decode
    import sub_word_pkg::*;
#(
    parameter int WA_W         = 5,
    parameter int CORE_WORDS   = 16,
    parameter int DMA_WORDS    = 8,
    parameter int CTL_WORD     = 28,
    parameter int SHADOW_WORDS = 25,
    parameter int SH_IW        = 5
) (
    input  logic [WA_W-1:0]  word_i,
    output tgt_e             tgt_o,
    output logic [SH_IW-1:0] flat_o
);
    int w;

    always_comb begin
        w      = int'(word_i);
        tgt_o  = TGT_NONE;
        flat_o = '0;
        if (w < CORE_WORDS) begin
            tgt_o  = TGT_CORE;
            flat_o = SH_IW'(w);
        end else if (w < CORE_WORDS + DMA_WORDS) begin
            tgt_o  = TGT_DMA;
            flat_o = SH_IW'(w);
        end else if (w == CTL_WORD) begin
            tgt_o  = TGT_CTL;
            flat_o = SH_IW'(SHADOW_WORDS - 1);
        end
    end
endmodule

// File: rtl/swa_merge.sv
module swa_merge #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [8*LANES-1:0] old_i,
    input  logic [8*LANES-1:0] data_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [OFF_W-1:0]   size_i,
    output logic [8*LANES-1:0] merged_o
);
    logic [8*LANES-1:0] shifted;
    logic [LANES-1:0]   lane_on;

    assign shifted = data_i << (8 * int'(off_i));

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        assign lane_on[L] = (int'(off_i) <= L) && ((L - int'(off_i)) <= int'(size_i));
        assign merged_o[8*L +: 8] = lane_on[L] ? shifted[8*L +: 8] : old_i[8*L +: 8];
    end
endmodule

// File: rtl/swa_extract.sv
module swa_extract #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [8*LANES-1:0] word_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [OFF_W-1:0]   size_i,
    output logic [8*LANES-1:0] data_o
);
    logic [8*LANES-1:0] shifted;

    assign shifted = word_i >> (8 * int'(off_i));

    for (genvar B = 0; B < LANES; B++) begin : g_byte
        assign data_o[8*B +: 8] = (B <= int'(size_i)) ? shifted[8*B +: 8] : 8'h00;
    end
endmodule

// File: rtl/sub_word_adapter.sv
module sub_word_adapter
    import sub_word_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 32,
    parameter int CORE_WORDS = 16,
    parameter int DMA_WORDS  = 8,
    parameter int CTL_WORD   = 28,
    parameter int CORE_IW    = $clog2(CORE_WORDS),
    parameter int DMA_IW     = $clog2(DMA_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [$clog2(DATA_W/8)-1:0]  req_size,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic                         core_wr,
    output logic                         core_rd,
    output logic [CORE_IW-1:0]           core_idx,
    output logic [DATA_W-1:0]            core_wdata,
    input  logic [DATA_W-1:0]            core_rdata,
    output logic                         dma_wr,
    output logic                         dma_rd,
    output logic [DMA_IW-1:0]            dma_idx,
    output logic [DATA_W-1:0]            dma_wdata,
    input  logic [DATA_W-1:0]            dma_rdata,
    output logic                         ctl_wr,
    output logic                         ctl_rd,
    output logic [DATA_W-1:0]            ctl_wdata,
    input  logic [DATA_W-1:0]            ctl_rdata
);
    localparam int LANES        = DATA_W / 8;
    localparam int OFF_W        = $clog2(LANES);
    localparam int WA_W         = ADDR_W - OFF_W;
    localparam int SHADOW_WORDS = CORE_WORDS + DMA_WORDS + 1;
    localparam int SH_IW        = $clog2(SHADOW_WORDS);

    typedef struct packed {
        logic                                rsp_valid;
        logic [DATA_W-1:0]                   rsp_data;
        logic [SHADOW_WORDS-1:0][DATA_W-1:0] shadow;
    } state_t;

    state_t st_d, st_q;

    logic [WA_W-1:0]   word;
    logic [OFF_W-1:0]  off;
    tgt_e              tgt;
    logic [SH_IW-1:0]  flat;
    logic              hit;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] live_word;
    logic [DATA_W-1:0] extracted;

    assign word = req_addr[ADDR_W-1:OFF_W];
    assign off  = req_addr[OFF_W-1:0];
    assign hit  = (tgt != TGT_NONE);

    swa_decode #(
        .WA_W(WA_W), .CORE_WORDS(CORE_WORDS), .DMA_WORDS(DMA_WORDS),
        .CTL_WORD(CTL_WORD), .SHADOW_WORDS(SHADOW_WORDS), .SH_IW(SH_IW)
    ) u_decode (
        .word_i(word), .tgt_o(tgt), .flat_o(flat)
    );

    assign old_word = st_q.shadow[flat];

    swa_merge #(.LANES(LANES), .OFF_W(OFF_W)) u_merge (
        .old_i(old_word), .data_i(req_wdata), .off_i(off),
        .size_i(req_size), .merged_o(merged)
    );

    always_comb begin
        case (tgt)
            TGT_CORE: live_word = core_rdata;
            TGT_DMA:  live_word = dma_rdata;
            TGT_CTL:  live_word = ctl_rdata;
            default:  live_word = '0;
        endcase
    end

    swa_extract #(.LANES(LANES), .OFF_W(OFF_W)) u_extract (
        .word_i(live_word), .off_i(off), .size_i(req_size), .data_o(extracted)
    );

    // target-side strobes, raised in the acceptance cycle
    assign req_ready  = 1'b1;
    assign core_wr    = req_valid &&  req_write && (tgt == TGT_CORE);
    assign core_rd    = req_valid && !req_write && (tgt == TGT_CORE);
    assign dma_wr     = req_valid &&  req_write && (tgt == TGT_DMA);
    assign dma_rd     = req_valid && !req_write && (tgt == TGT_DMA);
    assign ctl_wr     = req_valid &&  req_write && (tgt == TGT_CTL);
    assign ctl_rd     = req_valid && !req_write && (tgt == TGT_CTL);
    assign core_idx   = CORE_IW'(word);
    assign dma_idx    = DMA_IW'(word - WA_W'(CORE_WORDS));
    assign core_wdata = merged;
    assign dma_wdata  = merged;
    assign ctl_wdata  = merged;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_data  = '0;
        if (req_valid && hit) begin
            if (req_write) begin
                st_d.shadow[flat] = merged;
            end else begin
                st_d.rsp_data = extracted;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_data;
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 32,
    parameter int CORE_WORDS = 16,
    parameter int DMA_WORDS  = 8,
    parameter int CTL_WORD   = 28,
    parameter int CORE_IW    = $clog2(CORE_WORDS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [$clog2(DATA_W/8)-1:0] req_size,
    input logic [DATA_W-1:0]           req_wdata,
    input logic                        rsp_valid,
    input logic [DATA_W-1:0]           rsp_rdata,
    input logic                        core_wr,
    input logic                        core_rd,
    input logic [CORE_IW-1:0]          core_idx,
    input logic [DATA_W-1:0]           core_wdata,
    input logic                        dma_wr,
    input logic                        dma_rd,
    input logic                        ctl_wr,
    input logic                        ctl_rd
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    int  w;
    logic hole;
    logic [5:0] strobes;

    assign w       = int'(req_addr[ADDR_W-1:OFF_W]);
    assign hole    = (w >= CORE_WORDS + DMA_WORDS) && (w != CTL_WORD);
    assign strobes = {core_wr, core_rd, dma_wr, dma_rd, ctl_wr, ctl_rd};

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    p_write_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |-> !(core_rd || dma_rd || ctl_rd));

    p_hole_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && hole |-> strobes == 6'b0);

    p_hole_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && hole |=> rsp_rdata == '0);

    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_full_write_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && (&req_size) && (req_addr[OFF_W-1:0] == '0)
        && (w < CORE_WORDS) |-> core_wr && (core_wdata == req_wdata));

    p_byte_read_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && (req_size == '0) |=> rsp_rdata[DATA_W-1:8] == '0);

    p_core_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr || core_rd) |-> int'(core_idx) == w);
endmodule

bind sub_word_adapter swa_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_WORDS(CORE_WORDS),
    .DMA_WORDS(DMA_WORDS), .CTL_WORD(CTL_WORD), .CORE_IW(CORE_IW)
) u_chk (.*);

// File: tb/sub_word_adapter_tb.sv
module sub_word_adapter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        core_wr, core_rd, dma_wr, dma_rd, ctl_wr, ctl_rd;
    logic [3:0]  core_idx;
    logic [2:0]  dma_idx;
    logic [31:0] core_wdata, dma_wdata, ctl_wdata;
    logic [31:0] core_rdata, dma_rdata, ctl_rdata;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [31:0] tmem [0:24];
    logic [31:0] sh   [0:24];

    always #2 clk = ~clk;

    sub_word_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_wr(core_wr), .core_rd(core_rd), .core_idx(core_idx),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .dma_wr(dma_wr), .dma_rd(dma_rd), .dma_idx(dma_idx),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata)
    );

    // behavioural targets: live words that drift away from what was written
    always_comb begin
        core_rdata = tmem[int'(core_idx)];
        dma_rdata  = tmem[16 + int'(dma_idx)];
        ctl_rdata  = tmem[24];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int region(input int a);
        int wd = a / 4;
        if (wd < 16) return 0;
        if (wd < 24) return 1;
        if (wd == 28) return 2;
        return 3;
    endfunction

    function automatic int flat_of(input int a);
        int wd = a / 4;
        if (wd < 24) return wd;
        return 24;
    endfunction

    function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [31:0] d,
                                           input int off, input int nb);
        logic [31:0] r = old;
        for (int k = 0; k < nb; k++)
            if (off + k < 4) r[8*(off+k) +: 8] = d[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] bextract(input logic [31:0] v, input int off, input int nb);
        logic [31:0] r = '0;
        for (int k = 0; k < nb; k++)
            if (off + k < 4) r[8*k +: 8] = v[8*(off+k) +: 8];
        return r;
    endfunction

    task automatic acc(input bit w, input int a, input int sz, input logic [31:0] d,
                       input string wtag);
        int rg, f, off, nb;
        logic [5:0]  exp_st, act_st;
        logic [31:0] exp_w, exp_r;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = 7'(a);
        req_size = 2'(sz); req_wdata = d;
        #1;
        rg = region(a); f = flat_of(a); off = a % 4; nb = sz + 1;
        exp_st = '0;
        if (rg == 0) exp_st[5:4] = w ? 2'b10 : 2'b01;
        if (rg == 1) exp_st[3:2] = w ? 2'b10 : 2'b01;
        if (rg == 2) exp_st[1:0] = w ? 2'b10 : 2'b01;
        act_st = {core_wr, core_rd, dma_wr, dma_rd, ctl_wr, ctl_rd};
        if (rg == 3) tag = "R4 strobes";
        else if (w) tag = "R9 strobes";
        else if (rg == 0) tag = "R1 strobes";
        else if (rg == 1) tag = "R2 strobes";
        else tag = "R3 strobes";
        chk(act_st == exp_st, tag, 32'(act_st), 32'(exp_st));
        if (rg == 0) chk(int'(core_idx) == a / 4, "R1 index", 32'(core_idx), 32'(a / 4));
        if (rg == 1) chk(int'(dma_idx) == (a - 64) / 4, "R2 index", 32'(dma_idx), 32'((a - 64) / 4));
        exp_w = '0;
        if (w && rg != 3) begin
            exp_w = bmerge(sh[f], d, off, nb);
            if (wtag != "") tag = wtag;
            else if (off + nb > 4) tag = "R7 wdata";
            else if (nb == 4) tag = "R5 wdata";
            else tag = "R6 wdata";
            chk(core_wdata == exp_w && dma_wdata == exp_w && ctl_wdata == exp_w,
                tag, core_wdata, exp_w);
        end
        exp_r = (!w && rg != 3) ? bextract(tmem[f], off, nb) : 32'h0;
        @(posedge clk); #1;
        chk(rsp_valid == 1'b1, "R10 rsp_valid", 32'(rsp_valid), 32'h1);
        chk(rsp_rdata == exp_r, (rg == 3) ? "R4 rdata" : "R8 rdata", rsp_rdata, exp_r);
        if (w && rg != 3) begin
            sh[f]   = exp_w;
            tmem[f] = exp_w ^ 32'h5A5A_5A5A;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk({core_wr, core_rd, dma_wr, dma_rd, ctl_wr, ctl_rd} == 6'b0, "R10 idle strobes",
            32'({core_wr, core_rd, dma_wr, dma_rd, ctl_wr, ctl_rd}), 32'h0);
        @(posedge clk); #1;
        chk(rsp_valid == 1'b0, "R10 idle rsp_valid", 32'(rsp_valid), 32'h0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 25; i++) begin
            tmem[i] = 32'hC300_0000 ^ (i * 32'h0103_0507);
            sh[i]   = 32'h0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk(rsp_rdata == 32'h0, "R11 reset rsp_rdata", rsp_rdata, 32'h0);
        chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        // fresh word: unaddressed lanes come from a zero shadow
        acc(1, 8'h0D, 0, 32'h0000_00AB, "R11 shadow zero");
        acc(1, 8'h00, 3, 32'h1122_3344, "");     // full aligned core write
        acc(1, 8'h02, 0, 32'h0000_00EE, "");     // byte merge into written word
        acc(1, 8'h4F, 1, 32'h0000_BEEF, "");     // DMA, crosses word end
        acc(1, 8'h41, 2, 32'h00CA_FE01, "");     // DMA 3 bytes at lane 1
        acc(1, 8'h71, 1, 32'h0000_9876, "");     // control word, halfword
        acc(1, 8'h73, 3, 32'hDEAD_BEEF, "");     // control, only top lane kept
        acc(1, 8'h60, 3, 32'hFFFF_FFFF, "");     // hole write
        acc(1, 8'h7C, 0, 32'h0000_0055, "");     // hole write
        acc(0, 8'h00, 3, 32'h0, "");
        acc(0, 8'h03, 0, 32'h0, "");
        acc(0, 8'h01, 1, 32'h0, "");
        acc(0, 8'h42, 3, 32'h0, "");             // read past word end
        acc(0, 8'h70, 2, 32'h0, "");
        acc(0, 8'h64, 3, 32'h0, "");             // hole read
        acc(0, 8'h75, 0, 32'h0, "");             // hole read
        idle();
        acc(1, 8'h06, 0, 32'h0000_0077, "");     // merge must use shadow, not drifted target
        acc(1, 8'h0E, 1, 32'h0000_1234, "");
        idle();
        idle();
        for (int n = 0; n < 500; n++) begin
            acc(1'($urandom % 2), int'($urandom % 128), int'($urandom % 4), $urandom, "");
            if ($urandom % 8 == 0) idle();
        end
        idle();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule